// File: doc/BRIEF.md
# DMA Channel Trigger Sequencer

This block decides when a single DMA channel moves data. It takes a trigger, a mode setting, a burst-size selection and a 16-bit block length. From these it produces a per-byte request toward the bus side and accepts one done handshake per byte. It counts bytes inside the current burst and bytes left in the current block. From those counts it decides whether the next burst or block starts at once, waits for a trigger, or stops. Address arithmetic, bus arbitration and the data path live elsewhere.

A trigger normally moves a whole block. In single-shot mode a trigger moves only one burst. In block mode a repeat option chains blocks back to back with no further trigger. The channel holds at most one trigger that arrives while it is occupied and drops any more.

A double-buffer option links the channel to a partner. When a block completes, the channel pulses a link output and then blocks itself until the partner's link pulse comes back. Disabling the channel mid-burst lets the current burst finish before requests stop.

Top module: `dma_trig_seq`

## Requirements
- R1: After reset, xfer_req, busy, blk_done, trig_pending and link_out are all low.
- R2: With mode_single low and mode_repeat low, one trig_in pulse makes the channel transfer exactly one full block. It then issues no further request until another trigger arrives.
- R3: burst_sel encodes the burst length as 0 = 1 byte, 1 = 2, 2 = 4 and 3 = 8 bytes. A burst also ends early at the last byte of the block. In single-shot mode (mode_single high), each trigger moves exactly one such burst.
- R4: With mode_repeat high and mode_single low, the next block starts right after the last byte of the previous one, without a trigger, for as long as chan_en stays high.
- R5: A trigger that arrives while the channel cannot start at once is held as pending (trig_pending high) and serviced when the channel next becomes idle. While one is pending, further triggers are dropped.
- R6: block_len is a byte count. A value of 0 means 65536 bytes.
- R7: blk_done is a one-cycle pulse in the cycle after the handshake of a block's last byte. busy is high from the start of a block until that handshake, including the idle gaps between single-shot bursts.
- R8: xfer_req, once raised, stays high until xfer_done is seen. Each cycle with both xfer_req and xfer_done high transfers one byte.
- R9: If chan_en falls during a burst, the rest of that burst is still transferred. Requests then stop, chan_on falls, and the unfinished block is abandoned, so the next trigger after re-enabling starts a fresh full block.
- R10: The pending trigger is cleared when it is used to start a transfer, and whenever chan_en is low.
- R11: With dbuf_en high, the end of a block pulses link_out for one cycle. The channel then starts nothing until a link_in pulse arrives. Triggers in the meantime become pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable |
| trig_in | input | 1 | Transfer trigger, one pulse per request |
| mode_single | input | 1 | 1: each trigger moves one burst |
| mode_repeat | input | 1 | 1: chain blocks without a trigger (block mode) |
| dbuf_en | input | 1 | Double-buffer link with partner enabled |
| link_in | input | 1 | Partner finished its block; re-arms this channel |
| burst_sel | input | 2 | Burst length code: 1, 2, 4 or 8 bytes |
| block_len | input | 16 | Block size in bytes, 0 = 65536 |
| xfer_done | input | 1 | Bus-side handshake for the current byte |
| xfer_req | output | 1 | Per-byte transfer request |
| busy | output | 1 | A block is under way |
| blk_done | output | 1 | One-cycle block-complete pulse |
| trig_pending | output | 1 | A trigger is being held |
| link_out | output | 1 | One-cycle pulse that enables the partner |
| chan_on | output | 1 | Channel still active (enabled or finishing a burst) |

## Verification
On every cycle the assertions check several rules. A request is held until its handshake, and a request implies busy. A disabled, idle channel raises no request, and disabling clears the pending trigger. A held trigger survives while a transfer runs. A block-complete pulse follows a byte handshake, and a partner link pulse is followed by a silent cycle. Only the bench scenarios can show the totals: the byte count per block for every burst size, the burst-per-trigger split in single-shot mode, block chaining, dropping of surplus triggers, draining after a mid-burst disable, the 65536-byte zero-length case, and the hand-back through the link input.

// File: rtl/dts_pkg.sv
package dts_pkg;

   // Sequencer state: waiting for a start, or issuing byte requests.
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_XFER = 1'b1
   } dts_state_e;

   // Number of bits needed for a within-burst byte index.
   function automatic int burst_idx_w(input int bsel_w);
      int max_log;
      max_log = (1 << bsel_w) - 1;
      return (max_log > 0) ? max_log : 1;
   endfunction

endpackage

// File: rtl/dts_pend_gate.sv
// Single-entry trigger store: holds at most one trigger that could not
// start a transfer at once; surplus triggers are dropped.
module dts_pend_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic chan_en,
   input  logic trig_in,
   input  logic start,
   output logic pend
);

   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (!chan_en) begin
         pend_q <= 1'b0;
      end else if (start) begin
         // The held trigger (or the fresh one) is used now; a trigger in
         // the same cycle as a held one becomes the new held one.
         pend_q <= pend_q & trig_in;
      end else if (trig_in) begin
         pend_q <= 1'b1;
      end
   end

   assign pend = pend_q;

endmodule

// File: rtl/dts_link_arm.sv
// Double-buffer arming: at block end the channel disarms itself and
// announces to the partner; the partner's announcement re-arms it.
module dts_link_arm #(
   parameter int DBUF_SUPPORT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dbuf_en,
   input  logic blk_end,
   input  logic link_in,
   output logic armed,
   output logic link_out
);

   generate
      if (DBUF_SUPPORT != 0) begin : g_link
         logic armed_q;
         logic link_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               armed_q <= 1'b1;
               link_q  <= 1'b0;
            end else begin
               link_q <= blk_end & dbuf_en;
               if (!dbuf_en || link_in) begin
                  armed_q <= 1'b1;
               end else if (blk_end) begin
                  armed_q <= 1'b0;
               end
            end
         end

         assign armed    = armed_q;
         assign link_out = link_q;
      end else begin : g_nolink
         logic unused_link;
         assign unused_link = clk ^ rst_n ^ dbuf_en ^ blk_end ^ link_in;
         assign armed    = 1'b1;
         assign link_out = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/dts_counters.sv
// Byte-in-burst index and bytes-left-in-block counter.
module dts_counters #(
   parameter int LEN_W       = 16,
   parameter int BSEL_W      = 2,
   parameter int ZERO_IS_MAX = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_blk,
   input  logic              byte_ok,
   input  logic [LEN_W-1:0]  block_len,
   input  logic [BSEL_W-1:0] burst_sel,
   output logic              last_in_blk,
   output logic              last_in_burst
);

   localparam int MAX_LOG = (1 << BSEL_W) - 1;
   localparam int BCNT_W  = dts_pkg::burst_idx_w(BSEL_W);
   localparam int BLK_W   = LEN_W + 1;
   localparam logic [BCNT_W-1:0] IDX_ONES = '1;

   logic [BLK_W-1:0]  left_q;
   logic [BCNT_W-1:0] pos_q;
   logic [BLK_W-1:0]  load_val;
   logic [BSEL_W:0]   idx_shift;
   logic [BCNT_W-1:0] burst_last_idx;

   // Load value for a fresh block; the parameter picks how 0 is read.
   generate
      if (ZERO_IS_MAX != 0) begin : g_zero_full
         always_comb begin
            if (block_len == '0) begin
               load_val = BLK_W'(1) << LEN_W;
            end else begin
               load_val = {1'b0, block_len};
            end
         end
      end else begin : g_zero_one
         always_comb begin
            if (block_len == '0) begin
               load_val = BLK_W'(1);
            end else begin
               load_val = {1'b0, block_len};
            end
         end
      end
   endgenerate

   // Last byte index inside a burst: 2**burst_sel - 1.
   always_comb begin
      idx_shift      = (BSEL_W + 1)'(MAX_LOG) - {1'b0, burst_sel};
      burst_last_idx = IDX_ONES >> idx_shift;
   end

   assign last_in_blk   = (left_q == BLK_W'(1));
   assign last_in_burst = (pos_q == burst_last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (load_blk) begin
         left_q <= load_val;
      end else if (byte_ok) begin
         left_q <= left_q - BLK_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (byte_ok) begin
         if (last_in_burst || last_in_blk) begin
            pos_q <= '0;
         end else begin
            pos_q <= pos_q + BCNT_W'(1);
         end
      end else if (load_blk) begin
         pos_q <= '0;
      end
   end

endmodule

// File: rtl/dma_trig_seq.sv
module dma_trig_seq #(
   parameter int LEN_W        = 16,
   parameter int BSEL_W       = 2,
   parameter int ZERO_IS_MAX  = 1,
   parameter int DBUF_SUPPORT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_en,
   input  logic              trig_in,
   input  logic              mode_single,
   input  logic              mode_repeat,
   input  logic              dbuf_en,
   input  logic              link_in,
   input  logic [BSEL_W-1:0] burst_sel,
   input  logic [LEN_W-1:0]  block_len,
   input  logic              xfer_done,
   output logic              xfer_req,
   output logic              busy,
   output logic              blk_done,
   output logic              trig_pending,
   output logic              link_out,
   output logic              chan_on
);

   import dts_pkg::*;

   // Elaboration-time parameter checks.
   generate
      if (LEN_W < 2 || LEN_W > 24) begin : g_bad_len
         $error("dma_trig_seq: LEN_W out of range");
      end
      if (BSEL_W < 1 || BSEL_W > 3) begin : g_bad_bsel
         $error("dma_trig_seq: BSEL_W out of range");
      end
      if (ZERO_IS_MAX != 0 && ZERO_IS_MAX != 1) begin : g_bad_zero
         $error("dma_trig_seq: ZERO_IS_MAX must be 0 or 1");
      end
   endgenerate

   dts_state_e state_q, state_d;
   logic mid_blk_q, mid_blk_d;
   logic blk_done_q;

   logic pend;
   logic armed;
   logic en_ok;
   logic go;
   logic byte_ok;
   logic blk_end;
   logic brst_end;
   logic rpt_go;
   logic load_blk;
   logic last_in_blk;
   logic last_in_burst;
   logic in_xfer;

   assign in_xfer  = (state_q == ST_XFER);
   assign en_ok    = chan_en & armed;
   assign go       = (state_q == ST_IDLE) & en_ok & (pend | trig_in);
   assign byte_ok  = in_xfer & xfer_done;
   assign blk_end  = byte_ok & last_in_blk;
   assign brst_end = byte_ok & last_in_burst;
   assign rpt_go   = blk_end & mode_repeat & ~mode_single & chan_en & ~dbuf_en;
   assign load_blk = (go & ~mid_blk_q) | rpt_go;

   dts_pend_gate u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .chan_en (chan_en),
      .trig_in (trig_in),
      .start   (go),
      .pend    (pend)
   );

   dts_link_arm #(
      .DBUF_SUPPORT (DBUF_SUPPORT)
   ) u_link (
      .clk      (clk),
      .rst_n    (rst_n),
      .dbuf_en  (dbuf_en),
      .blk_end  (blk_end),
      .link_in  (link_in),
      .armed    (armed),
      .link_out (link_out)
   );

   dts_counters #(
      .LEN_W       (LEN_W),
      .BSEL_W      (BSEL_W),
      .ZERO_IS_MAX (ZERO_IS_MAX)
   ) u_cnt (
      .clk           (clk),
      .rst_n         (rst_n),
      .load_blk      (load_blk),
      .byte_ok       (byte_ok),
      .block_len     (block_len),
      .burst_sel     (burst_sel),
      .last_in_blk   (last_in_blk),
      .last_in_burst (last_in_burst)
   );

   // Next-state logic.
   always_comb begin
      state_d   = state_q;
      mid_blk_d = mid_blk_q;
      unique case (state_q)
         ST_IDLE: begin
            if (go) begin
               state_d   = ST_XFER;
               mid_blk_d = 1'b1;
            end else if (!chan_en) begin
               // Abandon a single-shot block left half done.
               mid_blk_d = 1'b0;
            end
         end
         ST_XFER: begin
            if (blk_end) begin
               if (rpt_go) begin
                  state_d   = ST_XFER;
                  mid_blk_d = 1'b1;
               end else begin
                  state_d   = ST_IDLE;
                  mid_blk_d = 1'b0;
               end
            end else if (brst_end) begin
               if (!chan_en) begin
                  state_d   = ST_IDLE;
                  mid_blk_d = 1'b0;
               end else if (mode_single) begin
                  state_d   = ST_IDLE;
               end
            end
         end
         default: begin
            state_d   = ST_IDLE;
            mid_blk_d = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         mid_blk_q  <= 1'b0;
         blk_done_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         mid_blk_q  <= mid_blk_d;
         blk_done_q <= blk_end;
      end
   end

   assign xfer_req     = in_xfer;
   assign busy         = in_xfer | mid_blk_q;
   assign blk_done     = blk_done_q;
   assign trig_pending = pend;
   assign chan_on      = chan_en | in_xfer;

endmodule

// File: rtl/dts_checker.sv
module dts_checker (
   input logic clk,
   input logic rst_n,
   input logic chan_en,
   input logic xfer_req,
   input logic xfer_done,
   input logic busy,
   input logic blk_done,
   input logic trig_pending,
   input logic link_out
);

   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && !xfer_done) |=> xfer_req)
      else $error("req_hold_chk");

   // R7
   req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> busy)
      else $error("req_busy_chk");

   // R7
   done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_done |-> $past(xfer_req && xfer_done))
      else $error("done_src_chk");

   // R9
   idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!chan_en && !xfer_req) |=> !xfer_req)
      else $error("idle_off_chk");

   // R10
   pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> !trig_pending)
      else $error("pend_clear_chk");

   // R5
   pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_pending && xfer_req && chan_en) |=> trig_pending)
      else $error("pend_keep_chk");

   // R11
   link_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      link_out |=> !xfer_req)
      else $error("link_wait_chk");

endmodule

bind dma_trig_seq dts_checker u_dts_chk (.*);

// File: tb/dma_trig_seq_bench.sv
module dma_trig_seq_bench;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chan_en = 1'b0;
   logic        trig_in = 1'b0;
   logic        mode_single = 1'b0;
   logic        mode_repeat = 1'b0;
   logic        dbuf_en = 1'b0;
   logic        link_in = 1'b0;
   logic [1:0]  burst_sel = 2'd0;
   logic [15:0] block_len = 16'd1;
   logic        stall = 1'b0;
   logic        xfer_done;
   logic        xfer_req, busy, blk_done, trig_pending, link_out, chan_on;

   int tests = 0;
   int fails = 0;
   int nbytes = 0;
   int nblk = 0;
   int nlink = 0;
   int hold_viol = 0;
   int cyc = 0;
   logic prev_wait = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   // Bus model: answers every cycle, or every other cycle when stalling.
   assign xfer_done = xfer_req & (stall ? cyc[0] : 1'b1);

   dma_trig_seq u_dma_trig_seq (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .trig_in(trig_in),
      .mode_single(mode_single), .mode_repeat(mode_repeat),
      .dbuf_en(dbuf_en), .link_in(link_in), .burst_sel(burst_sel),
      .block_len(block_len), .xfer_done(xfer_done), .xfer_req(xfer_req),
      .busy(busy), .blk_done(blk_done), .trig_pending(trig_pending),
      .link_out(link_out), .chan_on(chan_on)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (xfer_req && xfer_done) nbytes <= nbytes + 1;
      if (blk_done) nblk <= nblk + 1;
      if (link_out) nlink <= nlink + 1;
      if (rst_n && prev_wait && !xfer_req) hold_viol <= hold_viol + 1;
      prev_wait <= rst_n && xfer_req && !xfer_done;
   end

   task automatic check(input bit ok, input string what, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d", what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_trig();
      @(negedge clk) trig_in = 1'b1;
      @(negedge clk) trig_in = 1'b0;
   endtask

   task automatic wait_blk(input int base, input int want, input int lim);
      int n = 0;
      while ((nblk - base) < want && n < lim) begin
         @(negedge clk);
         n++;
      end
   endtask

   function automatic int burst_bytes(input int sel);
      return 1 << sel;
   endfunction

   initial begin
      int b0, k0, l0;
      tick(3);
      @(negedge clk) rst_n = 1'b1;
      tick(1);
      // R1
      check(!xfer_req && !busy && !blk_done && !trig_pending && !link_out,
            "R1 reset outputs", {xfer_req, busy, blk_done, trig_pending, link_out}, 0);
      chan_en = 1'b1;

      // R2 / R3 / R7: block mode sweep over burst codes and lengths
      for (int sel = 0; sel < 4; sel++) begin
         for (int li = 0; li < 4; li++) begin
            int len;
            len = (li == 0) ? 1 : (li == 1) ? 5 : (li == 2) ? 8 : 13;
            burst_sel = 2'(sel);
            block_len = 16'(len);
            stall = li[0];
            b0 = nbytes; k0 = nblk;
            pulse_trig();
            wait_blk(k0, 1, 200);
            tick(10);
            check(nbytes - b0 == len, $sformatf("R2 block bytes sel=%0d", sel), nbytes - b0, len);
            check(nblk - k0 == 1, "R7 one blk_done per block", nblk - k0, 1);
            check(!busy && !xfer_req, "R2 idle after block", busy, 0);
         end
      end

      // R3 / R7: single-shot, one burst per trigger
      mode_single = 1'b1;
      for (int sel = 0; sel < 4; sel++) begin
         int rem, got, bb;
         burst_sel = 2'(sel);
         block_len = 16'd13;
         stall = 1'b1;
         b0 = nbytes; k0 = nblk;
         rem = 13; got = 0; bb = burst_bytes(sel);
         while (rem > 0) begin
            pulse_trig();
            tick(40);
            got += (rem < bb) ? rem : bb;
            rem -= (rem < bb) ? rem : bb;
            check(nbytes - b0 == got, $sformatf("R3 single-shot bytes sel=%0d", sel), nbytes - b0, got);
            if (rem > 0) check(busy, "R7 busy between bursts", busy, 1);
         end
         check(nblk - k0 == 1 && !busy, "R3 single-shot block end", nblk - k0, 1);
      end
      mode_single = 1'b0;

      // R5 / R10: pending store, surplus triggers dropped
      burst_sel = 2'd1; block_len = 16'd12; stall = 1'b1;
      b0 = nbytes; k0 = nblk;
      pulse_trig();
      tick(3);
      check(!trig_pending, "R10 trigger used at start", trig_pending, 0);
      pulse_trig();
      check(trig_pending, "R5 trigger held during transfer", trig_pending, 1);
      pulse_trig();
      pulse_trig();
      wait_blk(k0, 2, 400);
      tick(20);
      check(nbytes - b0 == 24, "R5 one pending kept, extras lost", nbytes - b0, 24);
      check(nblk - k0 == 2 && !trig_pending, "R5 two blocks", nblk - k0, 2);

      // R4 / R9: repeat chains blocks; disable stops at a burst boundary
      mode_repeat = 1'b1; burst_sel = 2'd2; block_len = 16'd6; stall = 1'b0;
      b0 = nbytes; k0 = nblk;
      pulse_trig();
      tick(60);
      check(nblk - k0 >= 5, "R4 repeat chains blocks", nblk - k0, 5);
      chan_en = 1'b0;
      tick(20);
      check(((nbytes - b0) % 6 == 0) || ((nbytes - b0) % 6 == 4),
            "R9 repeat stops at burst end", (nbytes - b0) % 6, 0);
      l0 = nbytes;
      tick(10);
      check(nbytes == l0 && !chan_on, "R9 no request when disabled", nbytes - l0, 0);
      mode_repeat = 1'b0;

      // R9 / R10: disable mid-burst drains the burst, abandons the block
      chan_en = 1'b1; burst_sel = 2'd3; block_len = 16'd16; stall = 1'b1;
      tick(2);
      b0 = nbytes; k0 = nblk;
      pulse_trig();
      while (nbytes - b0 < 2) @(negedge clk);
      chan_en = 1'b0;
      check(chan_on, "R9 chan_on while draining", chan_on, 1);
      pulse_trig();
      tick(40);
      check(nbytes - b0 == 8, "R9 burst drained", nbytes - b0, 8);
      check(!chan_on && !trig_pending, "R10 disabled clears pending", trig_pending, 0);
      chan_en = 1'b1;
      tick(10);
      check(nbytes - b0 == 8, "R10 no start after re-enable", nbytes - b0, 8);
      pulse_trig();
      wait_blk(k0, 1, 200);
      tick(5);
      check(nbytes - b0 == 24, "R9 fresh full block", nbytes - b0, 24);

      // R11: double-buffer hand-off
      dbuf_en = 1'b1; burst_sel = 2'd1; block_len = 16'd4; stall = 1'b0;
      b0 = nbytes; k0 = nblk; l0 = nlink;
      pulse_trig();
      wait_blk(k0, 1, 100);
      tick(3);
      check(nlink - l0 == 1 && nbytes - b0 == 4, "R11 link pulse at block end", nlink - l0, 1);
      pulse_trig();
      tick(10);
      check(nbytes - b0 == 4 && trig_pending, "R11 disarmed, trigger pending", nbytes - b0, 4);
      @(negedge clk) link_in = 1'b1;
      @(negedge clk) link_in = 1'b0;
      tick(20);
      check(nbytes - b0 == 8 && nlink - l0 == 2, "R11 re-armed by link_in", nbytes - b0, 8);
      dbuf_en = 1'b0;
      tick(3);

      // R6: zero length means 65536 bytes
      burst_sel = 2'd3; block_len = 16'd0;
      b0 = nbytes; k0 = nblk;
      pulse_trig();
      wait_blk(k0, 1, 70000);
      tick(5);
      check(nbytes - b0 == 65536, "R6 zero length block", nbytes - b0, 65536);

      // R8
      check(hold_viol == 0, "R8 request held until done", hold_viol, 0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(CLK_P * 190000);
      tests++;
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule